// File: doc/BRIEF.md
# Multi-Trigger Failsafe Disarm Supervisor

This block watches five independent fault conditions on a vehicle controller and pulls a latched disarm line when any of them trips. Three of the conditions are silence timers: no valid frame from the remote control link, no heartbeat from the processing pipeline, and a motor that has stayed idle too long. Two are range checks taken every 10 ms: an altitude above the ceiling, and an autonomous velocity word that is not a finite single-precision number. All timing is counted in ticks of a 1 ms strobe, which a parameterised divider makes from the system clock.

When disarm is latched, the cause code keeps the first trigger that fired. It clears only when re-arm is requested and no trigger is active at that moment. A pilot override chooses the pilot velocity pair over the autonomous pair. Whatever the override says, the velocity outputs are forced to zero while the block is disarmed.

Top module: `failsafe_supervisor`

## Requirements
- R1: After reset, disarm_o is 1, cause_o is 7 (boot) and both velocity outputs are zero until the first re-arm.
- R2: If no link_valid_i pulse is seen for 500 consecutive ticks, disarm latches with cause 1. Each pulse restarts that count.
- R3: If no heartbeat_i pulse is seen for 100 consecutive ticks, disarm latches with cause 2. Each pulse restarts that count.
- R4: Altitude is unsigned centimetres and is sampled once every 10 ticks. A sampled value above 12000 latches disarm with cause 3. A value of exactly 12000 does not.
- R5: At each 10-tick sample, either autonomous velocity word having exponent bits [30:23] all ones (NaN or infinity) latches disarm with cause 4. The largest finite value, 0x7F7FFFFF, does not.
- R6: If motor_active_i stays low for 30000 consecutive ticks, disarm latches with cause 5. Any cycle with motor_active_i high restarts that count.
- R7: While disarmed, cause_o keeps the first cause that latched. Triggers that arrive later do not change it.
- R8: When several triggers rise in the same cycle, the lowest cause code wins: link 1, heartbeat 2, altitude 3, velocity 4, idle 5.
- R9: A rearm_i pulse clears disarm_o and sets cause_o to 0 only when no trigger is active. While a trigger is active the pulse is ignored.
- R10: While armed, vx_cmd_o and vy_cmd_o equal the pilot inputs when manual_mode_i is 1 and the autonomous inputs when it is 0. While disarmed, both are 0 whatever manual_mode_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_valid_i | input | 1 | One-cycle strobe for each valid remote link frame |
| heartbeat_i | input | 1 | One-cycle heartbeat strobe from the pipeline |
| altitude_cm_i | input | ALT_W (16) | Altitude in centimetres, unsigned |
| auto_vx_i | input | 32 | Autonomous x velocity, single-precision float |
| auto_vy_i | input | 32 | Autonomous y velocity, single-precision float |
| motor_active_i | input | 1 | High while the motors are being driven |
| manual_mode_i | input | 1 | Pilot override select |
| pilot_vx_i | input | 32 | Pilot x velocity |
| pilot_vy_i | input | 32 | Pilot y velocity |
| rearm_i | input | 1 | Re-arm request strobe |
| disarm_o | output | 1 | Latched disarm |
| cause_o | output | 3 | Cause code of the first trigger that latched |
| vx_cmd_o | output | 32 | Selected x velocity command |
| vy_cmd_o | output | 32 | Selected y velocity command |

## Verification
The altitude check and the velocity check run on the same 10-tick sample instant, so two of their faults can rise in the same clock cycle. To force this, the bench applies an over-ceiling altitude and a NaN velocity word on the same clock edge, and holds both until at least one sample instant has passed. The result is correct only if the latched cause is the altitude code (3) and not the velocity code (4). A separate step checks that a re-arm request arriving while a fault is still active leaves the block disarmed and keeps the cause.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_LINK  = 3'd1,
    CAUSE_HBEAT = 3'd2,
    CAUSE_ALT   = 3'd3,
    CAUSE_VEL   = 3'd4,
    CAUSE_IDLE  = 3'd5,
    CAUSE_BOOT  = 3'd7
  } cause_e;

  // trigger vector bit order; bit i maps to cause code i+1
  localparam int unsigned TRIG_LINK  = 0;
  localparam int unsigned TRIG_HBEAT = 1;
  localparam int unsigned TRIG_ALT   = 2;
  localparam int unsigned TRIG_VEL   = 3;
  localparam int unsigned TRIG_IDLE  = 4;
  localparam int unsigned NUM_TRIG   = 5;

  localparam int unsigned FLT_W   = 32;
  localparam int unsigned EXP_LSB = 23;
  localparam int unsigned EXP_MSB = 30;

  function automatic logic is_nonfinite(input logic [FLT_W-1:0] w);
    return &w[EXP_MSB:EXP_LSB];
  endfunction

endpackage

// File: rtl/fs_tick_gen.sv
module fs_tick_gen #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  generate
    if (DIV > 1) begin : g_tick_chk
      // ticks are single-cycle pulses (R2 timebase)
      assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/fs_timeout.sv
module fs_timeout #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic refresh_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (refresh_i)              cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);

  // refresh restarts the count (R2, R3, R6)
  assert_refresh_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> !expired_o);
  // an expired timer stays expired until refreshed (R6)
  assert_expiry_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !refresh_i) |=> expired_o);

endmodule

// File: rtl/fs_range_check.sv
module fs_range_check
  import fs_pkg::*;
#(
  parameter int unsigned PERIOD  = 10,
  parameter int unsigned ALT_W   = 16,
  parameter int unsigned ALT_MAX = 12000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ALT_W-1:0] altitude_i,
  input  logic [FLT_W-1:0] vx_i,
  input  logic [FLT_W-1:0] vy_i,
  output logic             alt_fault_o,
  output logic             vel_fault_o
);

  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PERIOD - 1);
  localparam logic [ALT_W-1:0] CEIL = ALT_W'(ALT_MAX);

  logic [PW-1:0] phase_q;
  logic          sample;
  logic          alt_q, vel_q;

  assign sample = tick_i && (phase_q == PLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (sample) phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q <= 1'b0;
      vel_q <= 1'b0;
    end else if (sample) begin
      alt_q <= (altitude_i > CEIL);
      vel_q <= is_nonfinite(vx_i) || is_nonfinite(vy_i);
    end
  end

  assign alt_fault_o = alt_q;
  assign vel_fault_o = vel_q;

  // faults move only at the periodic sample instant (R4, R5)
  assert_alt_sampled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(alt_fault_o));
  assert_vel_sampled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(vel_fault_o));

endmodule

// File: rtl/fs_disarm_latch.sv
module fs_disarm_latch
  import fs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                rearm_i,
  output logic                disarm_o,
  output cause_e              cause_o
);

  logic   disarm_q;
  cause_e cause_q, cause_d;
  logic   any_trig;

  assign any_trig = |trig_i;

  // lowest trigger index has priority (R8)
  always_comb begin
    cause_d = CAUSE_NONE;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (trig_i[i]) cause_d = cause_e'(3'(i + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disarm_q <= 1'b1;
      cause_q  <= CAUSE_BOOT;
    end else if (!disarm_q) begin
      if (any_trig) begin
        disarm_q <= 1'b1;
        cause_q  <= cause_d;
      end
    end else if (rearm_i && !any_trig) begin
      disarm_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end
  end

  assign disarm_o = disarm_q;
  assign cause_o  = cause_q;

  assert_cause_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_o && !rearm_i) |=> (disarm_o && $stable(cause_o)));
  assert_rearm_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_o && any_trig) |=> disarm_o);
  assert_trip_has_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disarm_o) |-> (cause_o != CAUSE_NONE && cause_o != CAUSE_BOOT));
  assert_armed_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disarm_o |-> cause_o == CAUSE_NONE);

endmodule

// File: rtl/failsafe_supervisor.sv
module failsafe_supervisor
  import fs_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 125000,
  parameter int unsigned LINK_MS     = 500,
  parameter int unsigned HBEAT_MS    = 100,
  parameter int unsigned IDLE_MS     = 30000,
  parameter int unsigned CHECK_MS    = 10,
  parameter int unsigned ALT_W       = 16,
  parameter int unsigned ALT_CEIL_CM = 12000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_valid_i,
  input  logic             heartbeat_i,
  input  logic [ALT_W-1:0] altitude_cm_i,
  input  logic [31:0]      auto_vx_i,
  input  logic [31:0]      auto_vy_i,
  input  logic             motor_active_i,
  input  logic             manual_mode_i,
  input  logic [31:0]      pilot_vx_i,
  input  logic [31:0]      pilot_vy_i,
  input  logic             rearm_i,
  output logic             disarm_o,
  output logic [2:0]       cause_o,
  output logic [31:0]      vx_cmd_o,
  output logic [31:0]      vy_cmd_o
);

  localparam int unsigned NUM_TMR = 3;

  function automatic int unsigned tmr_limit(input int unsigned idx);
    case (idx)
      0:       return LINK_MS;
      1:       return HBEAT_MS;
      default: return IDLE_MS;
    endcase
  endfunction

  logic                tick;
  logic [NUM_TMR-1:0]  tmr_refresh, tmr_expired;
  logic                alt_fault, vel_fault;
  logic [NUM_TRIG-1:0] trig;
  cause_e              cause;

  fs_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign tmr_refresh = {motor_active_i, heartbeat_i, link_valid_i};

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      fs_timeout #(.LIMIT(tmr_limit(g))) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .refresh_i (tmr_refresh[g]),
        .expired_o (tmr_expired[g])
      );
    end
  endgenerate

  fs_range_check #(
    .PERIOD  (CHECK_MS),
    .ALT_W   (ALT_W),
    .ALT_MAX (ALT_CEIL_CM)
  ) u_range (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .altitude_i  (altitude_cm_i),
    .vx_i        (auto_vx_i),
    .vy_i        (auto_vy_i),
    .alt_fault_o (alt_fault),
    .vel_fault_o (vel_fault)
  );

  always_comb begin
    trig             = '0;
    trig[TRIG_LINK]  = tmr_expired[0];
    trig[TRIG_HBEAT] = tmr_expired[1];
    trig[TRIG_ALT]   = alt_fault;
    trig[TRIG_VEL]   = vel_fault;
    trig[TRIG_IDLE]  = tmr_expired[2];
  end

  fs_disarm_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .rearm_i  (rearm_i),
    .disarm_o (disarm_o),
    .cause_o  (cause)
  );

  assign cause_o = cause;

  always_comb begin
    if (disarm_o) begin
      vx_cmd_o = '0;
      vy_cmd_o = '0;
    end else if (manual_mode_i) begin
      vx_cmd_o = pilot_vx_i;
      vy_cmd_o = pilot_vy_i;
    end else begin
      vx_cmd_o = auto_vx_i;
      vy_cmd_o = auto_vy_i;
    end
  end

  // a triggered source never leaves the block armed one cycle later (R2..R6)
  assert_trigger_disarms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig) |=> disarm_o);

endmodule

// File: tb/failsafe_supervisor_tb.sv
module failsafe_supervisor_tb;

  localparam int unsigned DIV = 2;

  typedef struct packed {
    logic        man;
    logic [31:0] avx;
    logic [31:0] pvx;
    logic [31:0] exp_vx;
  } mux_vec_t;

  localparam mux_vec_t MUX_VECS [0:5] = '{
    '{1'b0, 32'h3F80_0000, 32'h4000_0000, 32'h3F80_0000},
    '{1'b1, 32'h3F80_0000, 32'h4000_0000, 32'h4000_0000},
    '{1'b0, 32'hBF00_0000, 32'h0000_0000, 32'hBF00_0000},
    '{1'b1, 32'hBF00_0000, 32'h0000_0000, 32'h0000_0000},
    '{1'b1, 32'h0000_0000, 32'hC120_0000, 32'hC120_0000},
    '{1'b0, 32'h4248_0000, 32'hC120_0000, 32'h4248_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_valid = 1'b0, heartbeat = 1'b0;
  logic [15:0] altitude = '0;
  logic [31:0] auto_vx = '0, auto_vy = '0, pilot_vx = '0, pilot_vy = '0;
  logic        motor_active = 1'b1, manual = 1'b0, rearm = 1'b0;
  logic        disarm;
  logic [2:0]  cause;
  logic [31:0] vx_cmd, vy_cmd;

  logic link_en = 1'b1, hb_en = 1'b1;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  failsafe_supervisor #(.CLK_DIV(DIV)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .link_valid_i   (link_valid),
    .heartbeat_i    (heartbeat),
    .altitude_cm_i  (altitude),
    .auto_vx_i      (auto_vx),
    .auto_vy_i      (auto_vy),
    .motor_active_i (motor_active),
    .manual_mode_i  (manual),
    .pilot_vx_i     (pilot_vx),
    .pilot_vy_i     (pilot_vy),
    .rearm_i        (rearm),
    .disarm_o       (disarm),
    .cause_o        (cause),
    .vx_cmd_o       (vx_cmd),
    .vy_cmd_o       (vy_cmd)
  );

  // keep-alive strobes every 40 cycles (20 ticks)
  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      link_valid = (k % 40 == 0) && link_en;
      heartbeat  = (k % 40 == 0) && hb_en;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    auto_vx = 32'h3F80_0000;
    auto_vy = 32'h3F80_0000;
    cyc(3);
    #1;
    // R1 reset state
    chk("R1 disarm", 32'(disarm), 32'd1);
    chk("R1 cause", 32'(cause), 32'd7);
    chk("R1 vx zero", vx_cmd, 32'h0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 still disarmed", 32'(disarm), 32'd1);
    do_rearm();
    chk("R9 rearm clears", 32'(disarm), 32'd0);
    chk("R9 cause none", 32'(cause), 32'd0);

    // R10 mux vectors
    pilot_vy = 32'h4110_0000;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      manual  = MUX_VECS[i].man;
      auto_vx = MUX_VECS[i].avx;
      pilot_vx = MUX_VECS[i].pvx;
      #1;
      chk("R10 vx mux", vx_cmd, MUX_VECS[i].exp_vx);
      chk("R10 vy mux", vy_cmd, MUX_VECS[i].man ? 32'h4110_0000 : auto_vy);
    end

    // R4 boundary then trip
    altitude = 16'd12000;
    cyc(30);
    chk("R4 ceiling exact", 32'(disarm), 32'd0);
    altitude = 16'd12001;
    manual = 1'b1;
    cyc(30);
    chk("R4 over ceiling", 32'(disarm), 32'd1);
    chk("R4 cause", 32'(cause), 32'd3);
    chk("R10 disarmed zero vx", vx_cmd, 32'h0);
    chk("R10 disarmed zero vy", vy_cmd, 32'h0);
    // R7 later trigger does not overwrite
    auto_vx = 32'h7FC0_0000;
    cyc(30);
    chk("R7 cause held", 32'(cause), 32'd3);
    // R9 rearm ignored while active
    do_rearm();
    chk("R9 rearm ignored", 32'(disarm), 32'd1);
    chk("R9 cause kept", 32'(cause), 32'd3);
    altitude = 16'd500;
    auto_vx = 32'h3F80_0000;
    cyc(30);
    do_rearm();
    chk("R9 rearm after clear", 32'(disarm), 32'd0);

    // R5 max finite, then infinity
    manual = 1'b0;
    auto_vy = 32'h7F7F_FFFF;
    cyc(30);
    chk("R5 max finite", 32'(disarm), 32'd0);
    auto_vy = 32'h7F80_0000;
    cyc(30);
    chk("R5 inf trips", 32'(disarm), 32'd1);
    chk("R5 cause", 32'(cause), 32'd4);
    auto_vy = 32'h3F80_0000;
    cyc(30);
    do_rearm();
    chk("R9 rearm R5", 32'(disarm), 32'd0);

    // R8 altitude and velocity on the same sample
    @(negedge clk);
    altitude = 16'd13000;
    auto_vx  = 32'hFFC0_0001;
    cyc(30);
    chk("R8 same-cycle priority", 32'(cause), 32'd3);
    altitude = 16'd0;
    auto_vx  = 32'h3F80_0000;
    cyc(30);
    do_rearm();
    chk("R8 recover", 32'(disarm), 32'd0);

    // R3 heartbeat silence
    hb_en = 1'b0;
    cyc(140);
    chk("R3 before timeout", 32'(disarm), 32'd0);
    cyc(100);
    chk("R3 timeout", 32'(disarm), 32'd1);
    chk("R3 cause", 32'(cause), 32'd2);
    hb_en = 1'b1;
    cyc(60);
    do_rearm();
    chk("R3 recover", 32'(disarm), 32'd0);

    // R2 link silence
    link_en = 1'b0;
    cyc(900);
    chk("R2 before timeout", 32'(disarm), 32'd0);
    cyc(200);
    chk("R2 timeout", 32'(disarm), 32'd1);
    chk("R2 cause", 32'(cause), 32'd1);
    link_en = 1'b1;
    cyc(60);
    do_rearm();
    chk("R2 recover", 32'(disarm), 32'd0);

    // R6 motor idle with a restart in the middle
    motor_active = 1'b0;
    cyc(40000);
    motor_active = 1'b1;
    cyc(1);
    motor_active = 1'b0;
    cyc(40000);
    chk("R6 restart on activity", 32'(disarm), 32'd0);
    cyc(22000);
    chk("R6 idle timeout", 32'(disarm), 32'd1);
    chk("R6 cause", 32'(cause), 32'd5);

    finish_run();
  end

endmodule